// File: doc/BRIEF.md
# Nested Hardware Loop Sequencer

This block sits beside an instruction fetch unit. It repeats ranges of instruction addresses without any branch instruction being executed. Software configures up to `NLOOP` loop slots. Each slot holds a first address, a last address, an iteration count and an enable. Nesting follows slot index: slot 0 is the outermost loop and higher slots sit inside lower ones. A slot becomes live when fetch reaches its first address. When fetch reaches its last address, the innermost live slot that still has iterations left sends fetch back to its first address. Every live slot that is exhausted at that address retires in the same cycle and raises a one-cycle done flag.

The redirect is produced combinationally in the same cycle as the fetch address it answers, so there is no bubble between iterations. The execution side can ask to leave a live loop early: that loop and every loop nested inside it are dropped, and fetch resumes just past the loop's last address. The execution side can also jump from the current innermost loop into another configured loop, which restarts with its full count. Hazards between iterations are the responsibility of software. Nothing here checks them.

Top module: `zol_ctrl`

## Requirements
- R1: When a live slot's last address is fetched and that slot has iterations left, `redir_vld` is high in that same cycle with `redir_addr` equal to the slot's first address. A slot configured with count N issues its body exactly N times and then falls through with no redirect.
- R2: A slot whose configured count is 0 is skipped when its first address is fetched: the redirect goes to its last address + 1, the slot never becomes live, and slots nested inside it that share that first address do not start.
- R3: At least 6 slots nest. The innermost slot with iterations left wins the redirect. Exhausted inner slots that share the same last address retire in that cycle, and the enclosing slot's end test is evaluated in the same cycle.
- R4: `loop_done[i]` pulses for one cycle, in the fetch cycle of slot i's last address, when slot i finishes its final iteration.
- R5: `exit_req` with `exit_sel` naming a live slot redirects to that slot's last address + 1. It drops that slot and every higher-index slot, so later fetches of their last addresses give no redirect. Slots below it stay live.
- R6: `exit_req` naming a slot that is not live has no effect and produces no redirect.
- R7: `jump_req` while some slot is live drops the innermost live slot and every slot at or above `jump_sel`. It redirects to the first address of slot `jump_sel`, which restarts with its full count. If that slot's count is 0, the redirect goes to its last address + 1 instead. `exit_req` has priority over `jump_req`.
- R8: `jump_req` while no slot is live has no effect and produces no redirect.
- R9: After reset, no slot is live, and no redirect occurs without a fetch or a request.
- R10: A slot that finished restarts with its full configured count the next time its first address is fetched.
- R11: A slot with its enable bit low never starts.
- R12: A slot whose first and last addresses are equal repeats that single address N times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | NLOOP | Per-slot enable |
| cfg_start | input | NLOOP*ADDR_W | Per-slot first address, slot i at bits [i*ADDR_W +: ADDR_W] |
| cfg_end | input | NLOOP*ADDR_W | Per-slot last address, same packing |
| cfg_count | input | NLOOP*CNT_W | Per-slot iteration count, slot i at bits [i*CNT_W +: CNT_W] |
| fetch_vld | input | 1 | A fetch address is presented this cycle |
| fetch_addr | input | ADDR_W | Current fetch address |
| exit_req | input | 1 | Early-exit request |
| exit_sel | input | SEL_W | Slot to leave |
| jump_req | input | 1 | Jump-to-loop request |
| jump_sel | input | SEL_W | Target slot of the jump |
| redir_vld | output | 1 | Override the next fetch address |
| redir_addr | output | ADDR_W | Next fetch address when `redir_vld` is high |
| loop_done | output | NLOOP | Per-slot one-cycle completion flag |

## Verification
The bench runs a small fetch model that follows the redirects and counts how often each address is issued. An off-by-one count therefore shows up as a body executed N±1 times, and a broken nesting priority shows up as a wrong count in a six-deep nest (64 innermost iterations) or in two loops that share a last address. Skip-on-zero and single-address bodies are covered because a design that starts the slot anyway would issue the body, or would hang on one address. Exit and jump tests probe the last addresses of the dropped loops afterwards: a design that forgot to clear them would redirect again, and one that cleared too much would fail to redirect the surviving outer loop.

// File: rtl/zol_pkg.sv
package zol_pkg;
  typedef struct packed {
    logic load;
    logic clr;
    logic dec;
  } slot_ctl_t;
endpackage

// File: rtl/zol_prio.sv
module zol_prio #(
  parameter int N          = 6,
  parameter int IW         = 3,
  parameter bit HIGH_FIRST = 1'b1
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);
  generate
    if (HIGH_FIRST) begin : g_high
      always_comb begin
        found = |req;
        idx   = '0;
        for (int i = 0; i < N; i++) begin
          if (req[i]) idx = IW'(i);
        end
      end
    end else begin : g_low
      always_comb begin
        found = |req;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
          if (req[i]) idx = IW'(i);
        end
      end
    end
  endgenerate
endmodule

// File: rtl/zol_slot.sv
module zol_slot
  import zol_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  slot_ctl_t        ctl,
  input  logic [CNT_W-1:0] init_cnt,
  output logic             act_q,
  output logic [CNT_W-1:0] rem_q
);
  logic             act_d;
  logic [CNT_W-1:0] rem_d;
  logic             upd;

  assign upd = ctl.load | ctl.clr | ctl.dec;

  always_comb begin
    act_d = act_q;
    rem_d = rem_q;
    if (ctl.clr) begin
      act_d = 1'b0;
      rem_d = init_cnt;
    end else if (ctl.load) begin
      act_d = 1'b1;
      rem_d = ctl.dec ? init_cnt - CNT_W'(2) : init_cnt - CNT_W'(1);
    end else if (ctl.dec) begin
      rem_d = rem_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      rem_q <= '0;
    end else if (upd) begin
      act_q <= act_d;
      rem_q <= rem_d;
    end
  end
endmodule

// File: rtl/zol_ctrl.sv
module zol_ctrl
  import zol_pkg::*;
#(
  parameter int NLOOP  = 6,
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8,
  parameter int SEL_W  = (NLOOP > 1) ? $clog2(NLOOP) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NLOOP-1:0]        cfg_en,
  input  logic [NLOOP*ADDR_W-1:0] cfg_start,
  input  logic [NLOOP*ADDR_W-1:0] cfg_end,
  input  logic [NLOOP*CNT_W-1:0]  cfg_count,
  input  logic                    fetch_vld,
  input  logic [ADDR_W-1:0]       fetch_addr,
  input  logic                    exit_req,
  input  logic [SEL_W-1:0]        exit_sel,
  input  logic                    jump_req,
  input  logic [SEL_W-1:0]        jump_sel,
  output logic                    redir_vld,
  output logic [ADDR_W-1:0]       redir_addr,
  output logic [NLOOP-1:0]        loop_done
);
  localparam int SYNC_STAGES = 2;

  // reset: asserted asynchronously, released on the clock
  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign srst_n = rst_pipe[SYNC_STAGES-1];

  logic [ADDR_W-1:0] st  [NLOOP];
  logic [ADDR_W-1:0] lst [NLOOP];
  logic [CNT_W-1:0]  cnt [NLOOP];
  logic [CNT_W-1:0]  rem [NLOOP];
  slot_ctl_t         sctl[NLOOP];

  logic [NLOOP-1:0] act, at_start, at_end, cz, cand, skip_raw, enter;
  logic [NLOOP-1:0] hit, take, fin, dec, jload, ex_hot, jp_hot;

  logic             skip_found, win_found, inn_found;
  logic [SEL_W-1:0] skip_idx, win_idx, inn_idx;
  logic             exit_ok, jump_ok, ctl_any;

  // redirect operand muxes
  logic [ADDR_W-1:0] ex_end, jp_start, jp_end, win_start, skip_end;
  logic              jp_cz, jp_en;

  generate
    for (genvar i = 0; i < NLOOP; i++) begin : g_slot
      logic             blocked;
      logic             eact;
      logic [CNT_W-1:0] erem;

      assign st[i]  = cfg_start[i*ADDR_W +: ADDR_W];
      assign lst[i] = cfg_end[i*ADDR_W +: ADDR_W];
      assign cnt[i] = cfg_count[i*CNT_W +: CNT_W];

      assign at_start[i] = (fetch_addr == st[i]);
      assign at_end[i]   = (fetch_addr == lst[i]);
      assign cz[i]       = (cnt[i] == '0);
      assign ex_hot[i]   = (exit_sel == SEL_W'(i));
      assign jp_hot[i]   = (jump_sel == SEL_W'(i));

      // start detection, with an outer zero-count skip blocking inner starts
      assign cand[i]     = fetch_vld & cfg_en[i] & ~act[i] & at_start[i] & ~ctl_any;
      assign skip_raw[i] = cand[i] & cz[i];
      assign blocked     = skip_found & (int'(skip_idx) < i);
      assign enter[i]    = cand[i] & ~cz[i] & ~blocked;

      // effective state this cycle, counting a slot that starts right now
      assign eact = act[i] | enter[i];
      assign erem = act[i] ? rem[i] : cnt[i] - CNT_W'(1);

      assign hit[i]  = fetch_vld & ~ctl_any & eact & at_end[i];
      assign take[i] = hit[i] & (erem != '0);
      assign fin[i]  = hit[i] & ~take[i] & ~(win_found & (int'(win_idx) > i));
      assign dec[i]  = take[i] & win_found & (int'(win_idx) == i);

      assign jload[i] = jump_ok & jp_hot[i] & ~cz[i];

      assign sctl[i].load = (enter[i] & ~fin[i]) | jload[i];
      assign sctl[i].dec  = dec[i];
      assign sctl[i].clr  = fin[i]
                          | (exit_ok & (int'(exit_sel) <= i))
                          | (jump_ok & ~jload[i] &
                             ((int'(inn_idx) == i) | (int'(jump_sel) <= i)));

      zol_slot #(.CNT_W(CNT_W)) u_slot (
        .clk      (clk),
        .rst_n    (srst_n),
        .ctl      (sctl[i]),
        .init_cnt (cnt[i]),
        .act_q    (act[i]),
        .rem_q    (rem[i])
      );
    end
  endgenerate

  zol_prio #(.N(NLOOP), .IW(SEL_W), .HIGH_FIRST(1'b0)) u_skip_pick (
    .req (skip_raw), .found (skip_found), .idx (skip_idx)
  );
  zol_prio #(.N(NLOOP), .IW(SEL_W), .HIGH_FIRST(1'b1)) u_win_pick (
    .req (take), .found (win_found), .idx (win_idx)
  );
  zol_prio #(.N(NLOOP), .IW(SEL_W), .HIGH_FIRST(1'b1)) u_inner_pick (
    .req (act), .found (inn_found), .idx (inn_idx)
  );

  always_comb begin
    ex_end    = '0;
    jp_start  = '0;
    jp_end    = '0;
    jp_cz     = 1'b0;
    jp_en     = 1'b0;
    win_start = '0;
    skip_end  = '0;
    for (int i = 0; i < NLOOP; i++) begin
      ex_end    |= ex_hot[i] ? lst[i] : '0;
      jp_start  |= jp_hot[i] ? st[i]  : '0;
      jp_end    |= jp_hot[i] ? lst[i] : '0;
      jp_cz     |= jp_hot[i] & cz[i];
      jp_en     |= jp_hot[i] & cfg_en[i];
      win_start |= (win_idx  == SEL_W'(i)) ? st[i]  : '0;
      skip_end  |= (skip_idx == SEL_W'(i)) ? lst[i] : '0;
    end
  end

  assign exit_ok = exit_req & |(act & ex_hot);
  assign jump_ok = jump_req & ~exit_ok & inn_found & jp_en;
  assign ctl_any = exit_ok | jump_ok;

  always_comb begin
    redir_vld  = 1'b0;
    redir_addr = '0;
    if (exit_ok) begin
      redir_vld  = 1'b1;
      redir_addr = ex_end + ADDR_W'(1);
    end else if (jump_ok) begin
      redir_vld  = 1'b1;
      redir_addr = jp_cz ? jp_end + ADDR_W'(1) : jp_start;
    end else if (win_found) begin
      redir_vld  = 1'b1;
      redir_addr = win_start;
    end else if (skip_found) begin
      redir_vld  = 1'b1;
      redir_addr = skip_end + ADDR_W'(1);
    end
  end

  assign loop_done = fin;
endmodule

// File: rtl/zol_ctrl_chk.sv
module zol_ctrl_chk #(
  parameter int NLOOP  = 6,
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8,
  parameter int SEL_W  = 3
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [NLOOP-1:0]        cfg_en,
  input logic [NLOOP*ADDR_W-1:0] cfg_start,
  input logic [NLOOP*ADDR_W-1:0] cfg_end,
  input logic                    fetch_vld,
  input logic [ADDR_W-1:0]       fetch_addr,
  input logic                    exit_req,
  input logic [SEL_W-1:0]        exit_sel,
  input logic                    jump_req,
  input logic [SEL_W-1:0]        jump_sel,
  input logic                    redir_vld,
  input logic [ADDR_W-1:0]       redir_addr,
  input logic [NLOOP-1:0]        loop_done,
  input logic [NLOOP-1:0]        act_q
);
  logic              ex_live, jp_en;
  logic [ADDR_W-1:0] ex_last, jp_first, jp_last;

  assign ex_live  = ((act_q >> exit_sel) & NLOOP'(1)) != '0;
  assign jp_en    = ((cfg_en >> jump_sel) & NLOOP'(1)) != '0;
  assign ex_last  = ADDR_W'(cfg_end   >> (ADDR_W * int'(exit_sel)));
  assign jp_first = ADDR_W'(cfg_start >> (ADDR_W * int'(jump_sel)));
  assign jp_last  = ADDR_W'(cfg_end   >> (ADDR_W * int'(jump_sel)));

  AST_EXIT_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    exit_req && ex_live |-> redir_vld && redir_addr == ex_last + ADDR_W'(1)); // R5

  AST_EXIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    exit_req && ex_live |=> (act_q >> $past(exit_sel)) == '0); // R5

  AST_EXIT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    exit_req && !jump_req && act_q == '0 && !fetch_vld |-> !redir_vld); // R6

  AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    jump_req && !exit_req && act_q != '0 && jp_en && int'(jump_sel) < NLOOP
    |-> redir_vld && (redir_addr == jp_first || redir_addr == jp_last + ADDR_W'(1))); // R7

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_vld && !exit_req && !jump_req |-> !redir_vld); // R9

  generate
    for (genvar i = 0; i < NLOOP; i++) begin : g_done
      AST_DONE_AT_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        loop_done[i] |-> fetch_vld && fetch_addr == cfg_end[i*ADDR_W +: ADDR_W]); // R4
    end
  endgenerate
endmodule

bind zol_ctrl zol_ctrl_chk #(
  .NLOOP(NLOOP), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .SEL_W(SEL_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_en     (cfg_en),
  .cfg_start  (cfg_start),
  .cfg_end    (cfg_end),
  .fetch_vld  (fetch_vld),
  .fetch_addr (fetch_addr),
  .exit_req   (exit_req),
  .exit_sel   (exit_sel),
  .jump_req   (jump_req),
  .jump_sel   (jump_sel),
  .redir_vld  (redir_vld),
  .redir_addr (redir_addr),
  .loop_done  (loop_done),
  .act_q      (act)
);

// File: tb/zol_ctrl_test.sv
`timescale 1ns/1ps
module zol_ctrl_test;
  localparam int NLOOP  = 6;
  localparam int ADDR_W = 16;
  localparam int CNT_W  = 8;
  localparam int SEL_W  = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic [NLOOP-1:0]        cfg_en;
  logic [NLOOP*ADDR_W-1:0] cfg_start, cfg_end;
  logic [NLOOP*CNT_W-1:0]  cfg_count;
  logic                    fetch_vld;
  logic [ADDR_W-1:0]       fetch_addr;
  logic                    exit_req, jump_req;
  logic [SEL_W-1:0]        exit_sel, jump_sel;
  logic                    redir_vld;
  logic [ADDR_W-1:0]       redir_addr;
  logic [NLOOP-1:0]        loop_done;

  int checks = 0;
  int fails  = 0;
  int exec_cnt [256];
  int n_redir, n_done;
  logic             p_rv;
  logic [ADDR_W-1:0] p_ra;
  logic [NLOOP-1:0] p_dn;

  always #2.5 clk = ~clk;

  zol_ctrl #(.NLOOP(NLOOP), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .SEL_W(SEL_W)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_start(cfg_start),
    .cfg_end(cfg_end), .cfg_count(cfg_count), .fetch_vld(fetch_vld),
    .fetch_addr(fetch_addr), .exit_req(exit_req), .exit_sel(exit_sel),
    .jump_req(jump_req), .jump_sel(jump_sel), .redir_vld(redir_vld),
    .redir_addr(redir_addr), .loop_done(loop_done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_loop(input int s, input int first, input int last, input int n);
    cfg_en[s] = 1'b1;
    cfg_start[s*ADDR_W +: ADDR_W] = ADDR_W'(first);
    cfg_end[s*ADDR_W +: ADDR_W]   = ADDR_W'(last);
    cfg_count[s*CNT_W +: CNT_W]   = CNT_W'(n);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    fetch_vld = 1'b0; fetch_addr = '0;
    exit_req = 1'b0; exit_sel = '0; jump_req = 1'b0; jump_sel = '0;
    cfg_en = '0; cfg_start = '0; cfg_end = '0; cfg_count = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // fetch model: follows redirects, stops before issuing 'stop'
  task automatic run(input int pc0, input int stop, input int limit);
    int pc, steps;
    for (int a = 0; a < 256; a++) exec_cnt[a] = 0;
    n_redir = 0; n_done = 0; pc = pc0; steps = 0;
    while (pc != stop && steps < limit) begin
      fetch_vld = 1'b1; fetch_addr = ADDR_W'(pc);
      #1;
      exec_cnt[pc % 256]++;
      n_done += $countones(loop_done);
      if (redir_vld) begin
        n_redir++;
        pc = int'(redir_addr);
      end else begin
        pc = pc + 1;
      end
      steps++;
      @(negedge clk);
    end
    fetch_vld = 1'b0;
  endtask

  task automatic probe(input int addr, input bit ex, input bit jp, input int sel);
    fetch_vld = 1'b1; fetch_addr = ADDR_W'(addr);
    exit_req = ex; jump_req = jp;
    exit_sel = SEL_W'(sel); jump_sel = SEL_W'(sel);
    #1;
    p_rv = redir_vld; p_ra = redir_addr; p_dn = loop_done;
    @(negedge clk);
    fetch_vld = 1'b0; exit_req = 1'b0; jump_req = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    #1;
    check(!redir_vld && loop_done == '0, "R9 idle after reset", int'(redir_vld), 0);
    @(negedge clk);
    set_loop(0, 10, 13, 3);
    probe(5, 1'b0, 1'b0, 0);
    check(!p_rv && p_dn == '0, "R9 no redirect off-loop", int'(p_rv), 0);
  endtask

  task automatic t_single();
    do_reset();
    set_loop(0, 10, 13, 3);
    run(8, 14, 100);
    check(exec_cnt[12] == 3, "R1 body count", exec_cnt[12], 3);
    check(n_redir == 2, "R1 redirect count", n_redir, 2);
    check(n_done == 1, "R4 done pulses", n_done, 1);
    run(8, 14, 100);
    check(exec_cnt[12] == 3, "R10 body count after restart", exec_cnt[12], 3);
  endtask

  task automatic t_zero();
    do_reset();
    set_loop(0, 10, 14, 0);
    set_loop(1, 10, 13, 3);
    run(8, 20, 50);
    check(exec_cnt[12] == 0, "R2 skipped body", exec_cnt[12], 0);
    check(n_redir == 1 && n_done == 0, "R2 one skip redirect", n_redir, 1);
  endtask

  task automatic t_shared_end();
    do_reset();
    set_loop(0, 20, 30, 2);
    set_loop(1, 22, 30, 3);
    run(20, 31, 200);
    check(exec_cnt[30] == 6, "R3 shared last address", exec_cnt[30], 6);
    check(exec_cnt[21] == 2, "R3 outer body", exec_cnt[21], 2);
    check(n_done == 3, "R4 shared-end done pulses", n_done, 3);
  endtask

  task automatic t_deep();
    do_reset();
    for (int i = 0; i < NLOOP; i++) set_loop(i, 100 + i, 120 - i, 2);
    run(100, 121, 5000);
    check(exec_cnt[110] == 64, "R3 six-deep innermost", exec_cnt[110], 64);
    check(exec_cnt[116] == 32, "R3 six-deep level 4", exec_cnt[116], 32);
    check(exec_cnt[100] == 2, "R3 six-deep outermost", exec_cnt[100], 2);
    check(n_done == 63, "R4 six-deep done pulses", n_done, 63);
  endtask

  task automatic t_exit_outer();
    do_reset();
    set_loop(0, 10, 30, 5);
    set_loop(1, 15, 20, 5);
    run(10, 17, 100);
    probe(17, 1'b1, 1'b0, 0);
    check(p_rv && p_ra == 16'd31, "R5 exit target", int'(p_ra), 31);
    probe(20, 1'b0, 1'b0, 0);
    check(!p_rv, "R5 inner cleared", int'(p_rv), 0);
    probe(30, 1'b0, 1'b0, 0);
    check(!p_rv && p_dn == '0, "R5 outer cleared", int'(p_rv), 0);
  endtask

  task automatic t_exit_inner();
    do_reset();
    set_loop(0, 10, 30, 5);
    set_loop(1, 15, 20, 5);
    run(10, 17, 100);
    probe(17, 1'b1, 1'b0, 1);
    check(p_rv && p_ra == 16'd21, "R5 inner exit target", int'(p_ra), 21);
    probe(20, 1'b0, 1'b0, 0);
    check(!p_rv, "R5 exited loop silent", int'(p_rv), 0);
    probe(30, 1'b0, 1'b0, 0);
    check(p_rv && p_ra == 16'd10, "R5 outer survives", int'(p_ra), 10);
  endtask

  task automatic t_ignored();
    do_reset();
    set_loop(0, 10, 13, 3);
    set_loop(2, 50, 55, 2);
    probe(5, 1'b1, 1'b0, 0);
    check(!p_rv, "R6 exit of idle slot", int'(p_rv), 0);
    probe(5, 1'b0, 1'b1, 2);
    check(!p_rv, "R8 jump with nothing live", int'(p_rv), 0);
  endtask

  task automatic t_jump();
    do_reset();
    set_loop(0, 10, 30, 4);
    set_loop(1, 15, 20, 3);
    set_loop(2, 50, 55, 2);
    run(10, 17, 100);
    probe(17, 1'b0, 1'b1, 2);
    check(p_rv && p_ra == 16'd50, "R7 jump target", int'(p_ra), 50);
    run(50, 56, 100);
    check(exec_cnt[52] == 2 && n_done == 1, "R7 target full count", exec_cnt[52], 2);
    probe(20, 1'b0, 1'b0, 0);
    check(!p_rv, "R7 innermost dropped", int'(p_rv), 0);
    probe(30, 1'b0, 1'b0, 0);
    check(p_rv && p_ra == 16'd10, "R7 outer kept", int'(p_ra), 10);
  endtask

  task automatic t_disabled();
    do_reset();
    set_loop(0, 10, 12, 3);
    cfg_en[0] = 1'b0;
    run(8, 13, 50);
    check(exec_cnt[11] == 1 && n_redir == 0, "R11 disabled slot", exec_cnt[11], 1);
  endtask

  task automatic t_tiny();
    do_reset();
    set_loop(0, 10, 10, 4);
    run(9, 11, 50);
    check(exec_cnt[10] == 4, "R12 single-address body", exec_cnt[10], 4);
    check(n_done == 1, "R12 done once", n_done, 1);
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    fetch_vld = 1'b0; fetch_addr = '0;
    exit_req = 1'b0; exit_sel = '0; jump_req = 1'b0; jump_sel = '0;
    cfg_en = '0; cfg_start = '0; cfg_end = '0; cfg_count = '0;
    t_reset();
    t_single();
    t_zero();
    t_shared_end();
    t_deep();
    t_exit_outer();
    t_exit_inner();
    t_ignored();
    t_jump();
    t_disabled();
    t_tiny();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule